// File: doc/BRIEF.md
# Linked Context Breakpoint Checker

This block keeps a small bank of breakpoint comparator registers, each a control word and a context value. It answers one question without a clock: when another comparator links to entry `link_idx`, does that entry pass its context test? Only the upper slots of the bank can do context matching. The entry must be enabled. Its type code must be one the block supports. The context register picked by the type code, the current privilege level and the two hypervisor flags must then equal the stored value in all 32 bits.

The bank is written through a single synchronous write port. A write goes either to the control word or to the value word of one entry. The written word is visible from the clock edge that takes it. Until that edge, the match output is still computed from the old contents.

Top module: `ctxlink_checker`

## Requirements
- R1: A synchronous active-high reset clears every control and value word. After reset, `match` is 0 for every link index and every input pattern.
- R2: A link index passes only if NUM_BP-NUM_CTX <= link_idx < NUM_BP. With the defaults 6 and 2, that means only entries 4 and 5. Any other index, including 6..15, gives `match` = 0.
- R3: Control bit 0 enables the entry. When it is 0, `match` = 0.
- R4: The type code is control bits [23:20]. Type 3 chooses by privilege level:
  - Level 3 never matches.
  - Level 2 matches only when `host_mode` = 1, and then compares `ctx_hyp`.
  - Level 1 compares `ctx_kernel`.
- R5: Type 3 at level 0 compares `ctx_hyp` when `host_mode` and `trap_ge` are both 1. In every other case at level 0 it compares `ctx_kernel`.
- R6: Type 7 always compares `ctx_kernel`, and type 13 always compares `ctx_hyp`, at every privilege level.
- R7: Every other type code gives `match` = 0. This includes 9, 11 and 15.
- R8: The comparison is equality over all 32 bits of the chosen context against the value word. No bit is masked, so a difference only in bit 31 or only in bit 0 gives no match.
- R9: With `wr_en` = 1 on a clock edge, `wr_data` is written to entry `wr_idx`. It goes to the value word when `wr_is_value` = 1 and to the control word otherwise. A write to `wr_idx` >= NUM_BP changes no entry; for example, index 12 does not alias entry 4.
- R10: `match` is combinational on the stored words. In the cycle of a write to the queried entry, `match` still reflects the old contents. From the edge onward, it reflects the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bank |
| wr_is_value | input | 1 | 1 selects the value word, 0 the control word |
| wr_idx | input | LINK_W | Entry to write |
| wr_data | input | 32 | Word to write |
| link_idx | input | LINK_W | Linked entry under test |
| cur_el | input | 2 | Current privilege level 0..3 |
| host_mode | input | 1 | Hypervisor host-mode enable |
| trap_ge | input | 1 | Hypervisor trap-general-exceptions flag |
| ctx_kernel | input | 32 | Kernel-level context identifier |
| ctx_hyp | input | 32 | Hypervisor-level context identifier |
| match | output | 1 | Linked context comparator passes |

## Verification
A register write and a lookup of the same entry can fall in the same cycle. To provoke this, the bench queries entry 5 while a new value word for entry 5 is on the write port. Before the edge, `match` must still agree with the old value. After the edge, it must agree with the new value and no longer with the old one. The rest of the bench sweeps every type code, both enable states, all sixteen link indices, all privilege levels, both hypervisor flags and four context patterns, against a model built from the requirements.

// File: rtl/ctxlink_pkg.sv
package ctxlink_pkg;
  localparam int CTX_W    = 32;
  localparam int EN_BIT   = 0;
  localparam int TYPE_LSB = 20;
  localparam int TYPE_W   = 4;

  localparam logic [TYPE_W-1:0] BT_BY_LEVEL = 4'd3;
  localparam logic [TYPE_W-1:0] BT_KERNEL   = 4'd7;
  localparam logic [TYPE_W-1:0] BT_HYP      = 4'd13;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } level_e;

  function automatic logic [TYPE_W-1:0] type_of(input logic [CTX_W-1:0] ctrl);
    return ctrl[TYPE_LSB +: TYPE_W];
  endfunction
endpackage

// File: rtl/ctxlink_regbank.sv
module ctxlink_regbank #(
  parameter int NUM_BP = 6,
  parameter int LINK_W = 4,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_is_value,
  input  logic [LINK_W-1:0] wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [LINK_W-1:0] rd_idx,
  output logic [DW-1:0]     rd_ctrl,
  output logic [DW-1:0]     rd_value
);
  logic [DW-1:0] ctrl_q  [NUM_BP];
  logic [DW-1:0] value_q [NUM_BP];

  for (genvar g = 0; g < NUM_BP; g++) begin : g_entry
    localparam logic [LINK_W-1:0] MY_IDX = LINK_W'(g);
    logic hit;
    assign hit = wr_en && (wr_idx == MY_IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[g]  <= '0;
        value_q[g] <= '0;
      end else if (hit) begin
        if (wr_is_value) value_q[g] <= wr_data;
        else             ctrl_q[g]  <= wr_data;
      end
    end
  end

  always_comb begin
    rd_ctrl  = '0;
    rd_value = '0;
    for (int i = 0; i < NUM_BP; i++) begin
      if (rd_idx == LINK_W'(i)) begin
        rd_ctrl  = ctrl_q[i];
        rd_value = value_q[i];
      end
    end
  end
endmodule

// File: rtl/ctxlink_range.sv
module ctxlink_range #(
  parameter int NUM_BP  = 6,
  parameter int NUM_CTX = 2,
  parameter int LINK_W  = 4
) (
  input  logic [LINK_W-1:0] idx,
  output logic              in_range
);
  localparam int LOW = NUM_BP - NUM_CTX;

  always_comb begin
    in_range = (int'(idx) < NUM_BP) && (int'(idx) >= LOW);
  end
endmodule

// File: rtl/ctxlink_select.sv
module ctxlink_select
  import ctxlink_pkg::*;
(
  input  logic [TYPE_W-1:0] btype,
  input  logic [1:0]        cur_el,
  input  logic              host_mode,
  input  logic              trap_ge,
  input  logic [CTX_W-1:0]  ctx_kernel,
  input  logic [CTX_W-1:0]  ctx_hyp,
  output logic              sel_ok,
  output logic [CTX_W-1:0]  sel_ctx
);
  level_e lvl;
  assign lvl = level_e'(cur_el);

  always_comb begin
    sel_ok  = 1'b0;
    sel_ctx = ctx_kernel;
    unique case (btype)
      BT_BY_LEVEL: begin
        unique case (lvl)
          LVL_MON: sel_ok = 1'b0;
          LVL_HYP: begin
            sel_ok  = host_mode;
            sel_ctx = ctx_hyp;
          end
          LVL_KERNEL: begin
            sel_ok  = 1'b1;
            sel_ctx = ctx_kernel;
          end
          LVL_USER: begin
            sel_ok  = 1'b1;
            sel_ctx = (host_mode && trap_ge) ? ctx_hyp : ctx_kernel;
          end
          default: sel_ok = 1'b0;
        endcase
      end
      BT_KERNEL: begin
        sel_ok  = 1'b1;
        sel_ctx = ctx_kernel;
      end
      BT_HYP: begin
        sel_ok  = 1'b1;
        sel_ctx = ctx_hyp;
      end
      default: sel_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctxlink_checker.sv
module ctxlink_checker
  import ctxlink_pkg::*;
#(
  parameter int NUM_BP  = 6,
  parameter int NUM_CTX = 2,
  parameter int LINK_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_is_value,
  input  logic [LINK_W-1:0] wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [LINK_W-1:0] link_idx,
  input  logic [1:0]        cur_el,
  input  logic              host_mode,
  input  logic              trap_ge,
  input  logic [31:0]       ctx_kernel,
  input  logic [31:0]       ctx_hyp,
  output logic              match
);
  logic [CTX_W-1:0]  rd_ctrl;
  logic [CTX_W-1:0]  rd_value;
  logic              link_ok;
  logic              sel_ok;
  logic [CTX_W-1:0]  sel_ctx;
  logic [TYPE_W-1:0] btype;
  logic              unused_ctrl_bits;

  ctxlink_regbank #(.NUM_BP(NUM_BP), .LINK_W(LINK_W), .DW(CTX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_is_value(wr_is_value),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(link_idx),
    .rd_ctrl(rd_ctrl), .rd_value(rd_value)
  );

  ctxlink_range #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX), .LINK_W(LINK_W)) u_range (
    .idx(link_idx), .in_range(link_ok)
  );

  assign btype = type_of(rd_ctrl);

  ctxlink_select u_sel (
    .btype(btype), .cur_el(cur_el), .host_mode(host_mode), .trap_ge(trap_ge),
    .ctx_kernel(ctx_kernel), .ctx_hyp(ctx_hyp),
    .sel_ok(sel_ok), .sel_ctx(sel_ctx)
  );

  assign unused_ctrl_bits = ^{rd_ctrl[TYPE_LSB-1:EN_BIT+1], rd_ctrl[CTX_W-1:TYPE_LSB+TYPE_W]};

  always_comb begin
    match = link_ok && rd_ctrl[EN_BIT] && sel_ok && (sel_ctx == rd_value);
  end
endmodule

// File: rtl/ctxlink_checker_sva.sv
module ctxlink_checker_sva #(
  parameter int NUM_BP  = 6,
  parameter int NUM_CTX = 2,
  parameter int LINK_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [LINK_W-1:0] link_idx,
  input logic [1:0]        cur_el,
  input logic              host_mode,
  input logic              trap_ge,
  input logic [31:0]       ctx_kernel,
  input logic [31:0]       ctx_hyp,
  input logic [31:0]       rd_ctrl,
  input logic [31:0]       rd_value,
  input logic              match
);
  logic [3:0] ty;
  assign ty = rd_ctrl[23:20];

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !match); // R1
  AST_RANGE_GATE: assert property (@(posedge clk) disable iff (rst)
    ((int'(link_idx) >= NUM_BP) || (int'(link_idx) < NUM_BP - NUM_CTX)) |-> !match); // R2
  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst)
    !rd_ctrl[0] |-> !match); // R3
  AST_LEVEL3_NEVER: assert property (@(posedge clk) disable iff (rst)
    (ty == 4'd3 && cur_el == 2'd3) |-> !match); // R4
  AST_LEVEL2_NEEDS_HOST: assert property (@(posedge clk) disable iff (rst)
    (ty == 4'd3 && cur_el == 2'd2 && !host_mode) |-> !match); // R4
  AST_USER_HOST_PICKS_HYP: assert property (@(posedge clk) disable iff (rst)
    (ty == 4'd3 && cur_el == 2'd0 && host_mode && trap_ge && match) |-> (rd_value == ctx_hyp)); // R5
  AST_TYPE7_KERNEL: assert property (@(posedge clk) disable iff (rst)
    (ty == 4'd7 && match) |-> (rd_value == ctx_kernel)); // R6
  AST_TYPE13_HYP: assert property (@(posedge clk) disable iff (rst)
    (ty == 4'd13 && match) |-> (rd_value == ctx_hyp)); // R6
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (ty != 4'd3 && ty != 4'd7 && ty != 4'd13) |-> !match); // R7
  AST_FULL_EQUAL: assert property (@(posedge clk) disable iff (rst)
    match |-> (rd_value == ctx_kernel || rd_value == ctx_hyp)); // R8
endmodule

bind ctxlink_checker ctxlink_checker_sva #(
  .NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX), .LINK_W(LINK_W)
) u_sva (
  .clk(clk), .rst(rst), .link_idx(link_idx), .cur_el(cur_el),
  .host_mode(host_mode), .trap_ge(trap_ge), .ctx_kernel(ctx_kernel),
  .ctx_hyp(ctx_hyp), .rd_ctrl(rd_ctrl), .rd_value(rd_value), .match(match)
);

// File: tb/ctxlink_checker_tb.sv
`timescale 1ns/1ps
module ctxlink_checker_tb;
  localparam int NBP = 6;
  localparam int NCX = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_is_value = 1'b0;
  logic [3:0]  wr_idx = '0, link_idx = '0;
  logic [31:0] wr_data = '0, ctx_kernel = '0, ctx_hyp = '0;
  logic [1:0]  cur_el = '0;
  logic        host_mode = 1'b0, trap_ge = 1'b0;
  logic        match;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] mval [NBP];

  ctxlink_checker #(.NUM_BP(NBP), .NUM_CTX(NCX), .LINK_W(4)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_is_value(wr_is_value),
    .wr_idx(wr_idx), .wr_data(wr_data), .link_idx(link_idx), .cur_el(cur_el),
    .host_mode(host_mode), .trap_ge(trap_ge), .ctx_kernel(ctx_kernel),
    .ctx_hyp(ctx_hyp), .match(match)
  );

  always #10 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: match=%0b expected %0b (idx=%0d el=%0d hm=%0b tge=%0b)",
               tag, got, exp, link_idx, cur_el, host_mode, trap_ge);
    end
  endtask

  task automatic wr(input logic isv, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_is_value = isv; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic model(input int idx, input int ty, input bit en, input int el,
                                 input bit hm, input bit tge, input logic [31:0] ck,
                                 input logic [31:0] ch, input logic [31:0] v);
    if (idx >= NBP || idx < NBP - NCX) return 1'b0;
    if (!en) return 1'b0;
    case (ty)
      3: case (el)
           3: return 1'b0;
           2: return hm ? (ch == v) : 1'b0;
           1: return ck == v;
           default: return (hm && tge) ? (ch == v) : (ck == v);
         endcase
      7:  return ck == v;
      13: return ch == v;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input int idx, input int ty, input bit en, input int el, input int pat);
    if (idx >= NBP || idx < NBP - NCX) return "R2";
    if (!en) return "R3";
    if (pat == 3) return "R8";
    if (ty == 3) return (el == 0) ? "R5" : "R4";
    if (ty == 7 || ty == 13) return "R6";
    return "R7";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: zero bank, context 0 would equal a zero value, still no match
    for (int i = 0; i < 16; i++) begin
      for (int e = 0; e < 4; e++) begin
        link_idx = 4'(i); cur_el = 2'(e); host_mode = 1; trap_ge = 1;
        ctx_kernel = '0; ctx_hyp = '0; #1;
        check(match, 1'b0, "R1");
      end
    end

    // R9: value words to every slot
    for (int i = 0; i < NBP; i++) begin
      mval[i] = 32'h9E37_79B9 * (i + 1);
      wr(1'b1, i, mval[i]);
    end

    for (int ty = 0; ty < 16; ty++) begin
      for (int en = 0; en < 2; en++) begin
        for (int i = 0; i < NBP; i++) wr(1'b0, i, (32'(ty) << 20) | 32'(en) | 32'h0000_0F00);
        for (int i = 0; i < 16; i++) begin
          for (int e = 0; e < 4; e++) begin
            for (int f = 0; f < 4; f++) begin
              for (int p = 0; p < 4; p++) begin
                logic [31:0] v;
                v = (i < NBP) ? mval[i] : 32'h0;
                case (p)
                  0: begin ctx_kernel = v;  ctx_hyp = ~v; end
                  1: begin ctx_kernel = ~v; ctx_hyp = v;  end
                  2: begin ctx_kernel = v;  ctx_hyp = v;  end
                  default: begin ctx_kernel = v ^ 32'h8000_0000; ctx_hyp = v ^ 32'h1; end
                endcase
                link_idx = 4'(i); cur_el = 2'(e); host_mode = f[1]; trap_ge = f[0];
                #1;
                check(match, model(i, ty, en[0], e, f[1], f[0], ctx_kernel, ctx_hyp, v),
                      tag_of(i, ty, en[0], e, p));
              end
            end
          end
        end
      end
    end

    // R9: out-of-range write targets must not alias entry 4
    wr(1'b0, 4, 32'h0070_0001);
    wr(1'b1, 12, 32'h1234_5678);
    wr(1'b0, 12, 32'h0000_0000);
    link_idx = 4'd4; cur_el = 2'd1; host_mode = 0; trap_ge = 0;
    ctx_kernel = mval[4]; ctx_hyp = 32'h0; #1;
    check(match, 1'b1, "R9 alias write kept old entry");
    ctx_kernel = 32'h1234_5678; #1;
    check(match, 1'b0, "R9 alias write value absent");

    // R10: write and query of entry 5 in the same cycle
    wr(1'b0, 5, 32'h0070_0001);
    @(negedge clk);
    link_idx = 4'd5; cur_el = 2'd0; ctx_kernel = mval[5];
    wr_en = 1'b1; wr_is_value = 1'b1; wr_idx = 4'd5; wr_data = 32'hCAFE_0005;
    #5;
    check(match, 1'b1, "R10 pre-edge old value");
    @(negedge clk);
    wr_en = 1'b0; #1;
    check(match, 1'b0, "R10 post-edge old value");
    ctx_kernel = 32'hCAFE_0005; #1;
    check(match, 1'b1, "R10 post-edge new value");

    // R1: reset again clears programmed entries
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check(match, 1'b0, "R1 after second reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule